// File: doc/BRIEF.md
# Flash Buffered-Program Sequencer

This block sits on the host side of a NOR-style flash and turns one request to program a burst of 16-bit words into the series of bus writes that the flash needs for buffered programming. A request names the target sector (the word-address bits above the command-pattern field), the word address of the first word, and the number of words. The words follow on a separate valid/ready stream. The block emits an unlock write, a count write, one write per data word, and a commit write. It then pulses `done`.

Each command address is formed by placing a fixed low-order pattern under the sector bits. Before any bus cycle is issued, the request is checked against the 256-word write-buffer page and against the sector. A request that fails the check is dropped, `err` pulses, and the bus stays quiet. The bus side is a plain write strobe with an acknowledge. Every write holds its address and data until it is acknowledged. A byte-address copy of the bus address is also provided for hosts that address bytes.

Top module: `flash_bufprog_seq`

## Requirements
- R1: The first write of an accepted request goes to word address {sector, 12'h555}, with data 16'h0025.
- R2: The second write goes to {sector, 12'h000}, with data equal to the word count minus one. A count of 1 gives 16'h0000.
- R3: Next come exactly N data writes. Write i goes to start+i, in ascending order, and carries all 16 bits of the i-th stream word.
- R4: The final write goes to {sector, 12'h000} with data 16'h0029. Command writes always carry 8'h00 in bits 15:8.
- R5: A request is rejected when any of these holds:
  - N is 0.
  - N is greater than 256.
  - start[22:12] differs from the sector.
  - start[7:0]+N is greater than 256.
  On rejection, `err` is high for the one cycle after the request edge, `busy` stays low, and no write is issued.
- R6: While `bus_we` is high and `bus_ack` is low, `bus_we`, `bus_addr` and `bus_data` keep their values into the next cycle.
- R7: `done` is high for exactly the one cycle after the edge that samples the acknowledge of the commit write. `busy` is high from the cycle after acceptance through the `done` cycle, and low after it.
- R8: No data write is issued while the stream is stalled. `wd_ready` is high only while busy, in the load phase, with no write outstanding. Stream valid has no effect while idle.
- R9: `bus_byte_addr` always equals `bus_addr` shifted left by one, with bit 0 at zero.
- R10: Asserting `rst_n` low abandons the sequence. After the reset, `bus_we` and `busy` are low.
- R11: `req_ready` is high only when idle. A request presented while busy is ignored and produces no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_sector | input | 11 | Sector bits, word address [22:12] |
| req_start | input | 23 | Word address of the first data word |
| req_words | input | 9 | Number of words, 1 to 256 |
| wd_valid | input | 1 | Stream word present |
| wd_ready | output | 1 | Stream word taken on this edge |
| wd_data | input | 16 | Stream word |
| bus_we | output | 1 | Write strobe, held until acknowledged |
| bus_addr | output | 23 | Flash word address |
| bus_byte_addr | output | 24 | Host byte address, bit 0 zero |
| bus_data | output | 16 | Write data |
| bus_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
An accepted request makes `busy` and the first strobe visible one edge after acceptance, and a rejected one makes `err` visible one edge after it. Each later write appears at the edge that samples the previous acknowledge, or, for data, at the edge that takes the stream word. `done` follows the commit acknowledge by one edge. The bench raises the acknowledge on a falling edge after a programmable wait, and compares the write against the head of an expected-write queue at that moment. It checks `done` and `busy` on the next falling edge, and checks the rejection and reset results on the first falling edge after the edge that causes them.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_UNLOCK,
      ST_COUNT,
      ST_LOAD,
      ST_COMMIT,
      ST_FIN
   } seq_state_t;

   localparam logic [7:0] OPC_BUF_LOAD   = 8'h25;
   localparam logic [7:0] OPC_BUF_COMMIT = 8'h29;

   // command data lives on the low byte only; upper byte forced to zero
   function automatic logic [15:0] cmd_word(input logic [7:0] op);
      return {8'h00, op};
   endfunction

endpackage

// File: rtl/flash_cmd_addr.sv
module flash_cmd_addr #(
   parameter int ADDR_W = 23,
   parameter int LOW_W  = 12
) (
   input  logic [ADDR_W-LOW_W-1:0] sector,
   output logic [ADDR_W-1:0]       unlock_addr,
   output logic [ADDR_W-1:0]       base_addr
);
   logic [LOW_W-1:0] pattern;

   // alternating pattern, ones on even bit positions (0x555 for 12 bits)
   for (genvar b = 0; b < LOW_W; b++) begin : g_pat
      if (b % 2 == 0) begin : g_one
         assign pattern[b] = 1'b1;
      end else begin : g_zero
         assign pattern[b] = 1'b0;
      end
   end

   assign unlock_addr = {sector, pattern};
   assign base_addr   = {sector, {LOW_W{1'b0}}};

endmodule

// File: rtl/flash_req_check.sv
module flash_req_check #(
   parameter int ADDR_W = 23,
   parameter int LOW_W  = 12,
   parameter int PAGE_W = 8
) (
   input  logic [ADDR_W-LOW_W-1:0] sector,
   input  logic [ADDR_W-1:0]       start,
   input  logic [PAGE_W:0]         words,
   output logic                    ok
);
   localparam int PAGE_WORDS = 1 << PAGE_W;

   logic [PAGE_W+1:0] span_end;
   logic              cnt_ok, sect_ok, page_ok;

   assign span_end = {2'b00, start[PAGE_W-1:0]} + {1'b0, words};
   assign cnt_ok   = (words != '0) && ({1'b0, words} <= (PAGE_W+2)'(PAGE_WORDS));
   assign sect_ok  = (start[ADDR_W-1:LOW_W] == sector);
   assign page_ok  = (span_end <= (PAGE_W+2)'(PAGE_WORDS));
   assign ok       = cnt_ok && sect_ok && page_ok;

endmodule

// File: rtl/flash_byte_lane.sv
module flash_byte_lane #(
   parameter int ADDR_W = 23
) (
   input  logic [ADDR_W-1:0] word_addr,
   output logic [ADDR_W:0]   byte_addr
);
   assign byte_addr = {word_addr, 1'b0};
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
   import flash_seq_pkg::*;
#(
   parameter int ADDR_W = 23,
   parameter int CMD_LSB = 12,
   parameter int PAGE_W = 8,
   parameter int DATA_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [ADDR_W-CMD_LSB-1:0] req_sector,
   input  logic [ADDR_W-1:0]         req_start,
   input  logic [PAGE_W:0]           req_words,
   input  logic                      wd_valid,
   output logic                      wd_ready,
   input  logic [DATA_W-1:0]         wd_data,
   output logic                      bus_we,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic [ADDR_W:0]           bus_byte_addr,
   output logic [DATA_W-1:0]         bus_data,
   input  logic                      bus_ack,
   output logic                      busy,
   output logic                      done,
   output logic                      err
);
   localparam int SECT_W = ADDR_W - CMD_LSB;
   localparam int CNT_W  = PAGE_W + 1;

   if (CMD_LSB <= PAGE_W || SECT_W < 1) begin : g_bad_geom
      $error("flash_bufprog_seq: command field must exceed page and leave sector bits");
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("flash_bufprog_seq: data width must be 16");
   end

   seq_state_t        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              we_q, err_q;
   logic [SECT_W-1:0] sector_q;
   logic [ADDR_W-1:0] start_q;
   logic [CNT_W-1:0]  words_q, idx_q;

   logic [SECT_W-1:0] sector_sel;
   logic [ADDR_W-1:0] unlock_addr, base_addr;
   logic              req_ok;
   logic [CNT_W-1:0]  last_idx;

   assign sector_sel = (state_q == ST_IDLE) ? req_sector : sector_q;
   assign last_idx   = words_q - CNT_W'(1);

   flash_cmd_addr #(.ADDR_W(ADDR_W), .LOW_W(CMD_LSB)) u_cmd_addr (
      .sector      (sector_sel),
      .unlock_addr (unlock_addr),
      .base_addr   (base_addr)
   );

   flash_req_check #(.ADDR_W(ADDR_W), .LOW_W(CMD_LSB), .PAGE_W(PAGE_W)) u_req_check (
      .sector (req_sector),
      .start  (req_start),
      .words  (req_words),
      .ok     (req_ok)
   );

   flash_byte_lane #(.ADDR_W(ADDR_W)) u_byte_lane (
      .word_addr (addr_q),
      .byte_addr (bus_byte_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         data_q   <= '0;
         we_q     <= 1'b0;
         err_q    <= 1'b0;
         sector_q <= '0;
         start_q  <= '0;
         words_q  <= '0;
         idx_q    <= '0;
      end else begin
         err_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_ok) begin
                     state_q  <= ST_UNLOCK;
                     sector_q <= req_sector;
                     start_q  <= req_start;
                     words_q  <= req_words;
                     addr_q   <= unlock_addr;
                     data_q   <= cmd_word(OPC_BUF_LOAD);
                     we_q     <= 1'b1;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_UNLOCK: begin
               if (bus_ack) begin
                  state_q <= ST_COUNT;
                  addr_q  <= base_addr;
                  data_q  <= DATA_W'(last_idx);
               end
            end
            ST_COUNT: begin
               if (bus_ack) begin
                  state_q <= ST_LOAD;
                  we_q    <= 1'b0;
                  idx_q   <= '0;
               end
            end
            ST_LOAD: begin
               if (!we_q) begin
                  if (wd_valid) begin
                     we_q   <= 1'b1;
                     addr_q <= start_q + ADDR_W'(idx_q);
                     data_q <= wd_data;
                  end
               end else if (bus_ack) begin
                  if (idx_q == last_idx) begin
                     state_q <= ST_COMMIT;
                     addr_q  <= base_addr;
                     data_q  <= cmd_word(OPC_BUF_COMMIT);
                  end else begin
                     we_q  <= 1'b0;
                     idx_q <= idx_q + CNT_W'(1);
                  end
               end
            end
            ST_COMMIT: begin
               if (bus_ack) begin
                  state_q <= ST_FIN;
                  we_q    <= 1'b0;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign wd_ready  = (state_q == ST_LOAD) && !we_q;
   assign bus_we    = we_q;
   assign bus_addr  = addr_q;
   assign bus_data  = data_q;
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_FIN);
   assign err       = err_q;

endmodule

// File: rtl/flash_bufprog_seq_chk.sv
module flash_bufprog_seq_chk #(
   parameter int ADDR_W = 23,
   parameter int LOW_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              wd_ready,
   input logic              bus_we,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [ADDR_W:0]   bus_byte_addr,
   input logic [15:0]       bus_data,
   input logic              busy,
   input logic              done,
   input logic              err
);
   function automatic logic [LOW_W-1:0] unlock_pat();
      logic [LOW_W-1:0] p;
      for (int b = 0; b < LOW_W; b++) p[b] = (b % 2 == 0);
      return p;
   endfunction

   AST_UNLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> bus_we && bus_addr[LOW_W-1:0] == unlock_pat() && bus_data == 16'h0025); // R1

   AST_COMMIT_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(bus_we && bus_ack) && $past(bus_data) == 16'h0029
               && $past(bus_addr[LOW_W-1:0]) == '0); // R4

   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy && !bus_we); // R5

   AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && !bus_ack |=> bus_we && $stable(bus_addr) && $stable(bus_data)); // R6

   AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy ##1 !busy); // R7

   AST_READY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wd_ready |-> busy && !bus_we); // R8

   AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_byte_addr[0] == 1'b0 && bus_byte_addr[ADDR_W:1] == bus_addr); // R9

   AST_REQ_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy && !bus_we); // R11

endmodule

bind flash_bufprog_seq flash_bufprog_seq_chk #(.ADDR_W(ADDR_W), .LOW_W(CMD_LSB)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .wd_ready      (wd_ready),
   .bus_we        (bus_we),
   .bus_ack       (bus_ack),
   .bus_addr      (bus_addr),
   .bus_byte_addr (bus_byte_addr),
   .bus_data      (bus_data),
   .busy          (busy),
   .done          (done),
   .err           (err)
);

// File: tb/flash_bufprog_seq_tb_top.sv
`timescale 1ns/1ps
module flash_bufprog_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [10:0] req_sector = '0;
   logic [22:0] req_start = '0;
   logic [8:0]  req_words = '0;
   logic        wd_valid = 1'b0;
   logic        wd_ready;
   logic [15:0] wd_data = '0;
   logic        bus_we;
   logic [22:0] bus_addr;
   logic [23:0] bus_byte_addr;
   logic [15:0] bus_data;
   logic        bus_ack = 1'b0;
   logic        busy, done, err;

   typedef struct {
      logic [22:0] a;
      logic [15:0] d;
      bit          commit;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   int   ack_delay = 0;
   int   wait_c = 0;
   bit   done_pend = 1'b0;

   always #2.5 clk = ~clk;

   flash_bufprog_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sector(req_sector), .req_start(req_start), .req_words(req_words),
      .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_byte_addr(bus_byte_addr),
      .bus_data(bus_data), .bus_ack(bus_ack), .busy(busy), .done(done), .err(err)
   );

   task automatic check(input bit cond, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] word_of(input int i, input logic [10:0] s);
      return 16'(16'hC3A5 ^ (i * 16'h0101) ^ {5'd0, s});
   endfunction

   // monitor / bus responder: compares each write at the point it is acknowledged
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0;
         wait_c = 0;
         done_pend = 1'b0;
      end else begin
         if (done_pend) begin
            check(done && busy, "R7", "done one cycle after commit ack",
                  {30'd0, done, busy}, 32'd3);
            done_pend = 1'b0;
         end
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_we) begin
            if (wait_c != 0) begin
               wait_c--;
            end else begin
               check(bus_byte_addr == {bus_addr, 1'b0}, "R9", "byte address",
                     32'(bus_byte_addr), 32'({bus_addr, 1'b0}));
               if (exp_q.size() == 0) begin
                  check(1'b0, "R11", "unexpected write", 32'(bus_addr), 32'hFFFFFFFF);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  check(bus_addr == e.a, e.tag, "write address", 32'(bus_addr), 32'(e.a));
                  check(bus_data == e.d, e.tag, "write data", 32'(bus_data), 32'(e.d));
                  if (e.commit) done_pend = 1'b1;
               end
               bus_ack = 1'b1;
               wait_c = ack_delay;
            end
         end
      end
   end

   task automatic push(input logic [22:0] a, input logic [15:0] d, input bit c, input string t);
      exp_t e;
      e.a = a; e.d = d; e.commit = c; e.tag = t;
      exp_q.push_back(e);
   endtask

   task automatic run_req(input logic [10:0] s, input logic [22:0] st, input int n,
                          input bit stall, input bit ok);
      if (ok) begin
         push({s, 12'h555}, 16'h0025, 1'b0, "R1");
         push({s, 12'h000}, 16'(n - 1), 1'b0, "R2");
         for (int i = 0; i < n; i++) push(st + 23'(i), word_of(i, s), 1'b0, "R3");
         push({s, 12'h000}, 16'h0029, 1'b1, "R4");
      end
      @(negedge clk);
      req_valid = 1'b1; req_sector = s; req_start = st; req_words = 9'(n);
      @(negedge clk);
      req_valid = 1'b0;
      if (!ok) begin
         check(err && !busy && !bus_we, "R5", "reject pulse, no busy/write",
               {29'd0, err, busy, bus_we}, 32'd4);
         @(negedge clk);
         check(!err && !bus_we && !busy, "R5", "reject leaves bus idle",
               {29'd0, err, busy, bus_we}, 32'd0);
         return;
      end
      check(busy && bus_we && !req_ready, "R7", "busy after accept",
            {29'd0, busy, bus_we, req_ready}, 32'd6);
      for (int i = 0; i < n; i++) begin
         if (stall && (i % 2 == 1)) begin
            wd_valid = 1'b0;
            req_valid = 1'b1; req_sector = s + 11'd1; req_start = {s + 11'd1, 12'h000};
            repeat (8) @(negedge clk);
            req_valid = 1'b0;
            check(!bus_we && wd_ready, "R8", "stalled stream issues no write",
                  {30'd0, bus_we, wd_ready}, 32'd1);
            check(!req_ready, "R11", "request ignored while busy", 32'(req_ready), 32'd0);
         end
         wd_valid = 1'b1;
         wd_data = word_of(i, s);
         while (!wd_ready) @(negedge clk);
         @(negedge clk);
         wd_valid = 1'b0;
      end
      for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
      @(negedge clk);
      check(!busy && !done && req_ready, "R7", "idle after done",
            {29'd0, busy, done, req_ready}, 32'd1);
      check(exp_q.size() == 0, "R3", "all writes seen", 32'(exp_q.size()), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !bus_we && !done && !err && req_ready, "R10", "reset state",
            {27'd0, busy, bus_we, done, err, req_ready}, 32'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // stream valid while idle does nothing
      wd_valid = 1'b1; wd_data = 16'hFFFF;
      repeat (4) @(negedge clk);
      check(!wd_ready && !bus_we && !busy, "R8", "stream ignored when idle",
            {29'd0, wd_ready, bus_we, busy}, 32'd0);
      wd_valid = 1'b0;

      ack_delay = 0;
      run_req(11'h015, {11'h015, 12'h100}, 1, 1'b0, 1'b1);
      ack_delay = 2;
      run_req(11'h2A3, {11'h2A3, 12'h7F8}, 6, 1'b1, 1'b1);
      ack_delay = 1;
      run_req(11'h7FF, {11'h7FF, 12'hEF0}, 16, 1'b0, 1'b1);
      ack_delay = 0;
      run_req(11'h001, {11'h001, 12'h300}, 256, 1'b0, 1'b1);

      // rejections
      run_req(11'h010, {11'h010, 12'h2F1}, 16, 1'b0, 1'b0);
      run_req(11'h010, {11'h010, 12'h200}, 0, 1'b0, 1'b0);
      run_req(11'h010, {11'h010, 12'h000}, 257, 1'b0, 1'b0);
      run_req(11'h010, {11'h011, 12'h000}, 4, 1'b0, 1'b0);

      // reset in the middle of a sequence
      ack_delay = 1;
      push({11'h055, 12'h555}, 16'h0025, 1'b0, "R1");
      push({11'h055, 12'h000}, 16'h0003, 1'b0, "R2");
      @(negedge clk);
      req_valid = 1'b1; req_sector = 11'h055; req_start = {11'h055, 12'h040}; req_words = 9'd4;
      @(negedge clk);
      req_valid = 1'b0;
      for (int t = 0; t < 50 && exp_q.size() != 0; t++) @(negedge clk);
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!bus_we && !busy, "R10", "abandon on reset", {30'd0, bus_we, busy}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!bus_we && !busy && req_ready, "R10", "idle after reset release",
            {29'd0, bus_we, busy, req_ready}, 32'd1);

      ack_delay = 0;
      run_req(11'h055, {11'h055, 12'h040}, 3, 1'b0, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule